// File: doc/BRIEF.md
# Processor Status Flag Register

This block keeps the processor's status byte. Three low bits are arithmetic flags (zero, half-byte carry, carry) and two bits above them record why the core last woke or stopped (watchdog expiry and entry into sleep). Each cycle the register combines two update sources. The first is the set of flag results from the instruction now executing, with one update enable per flag. The second is an ordinary data write, used when that instruction names the status byte as its destination.

Flag results from the instruction win over the data write. If an instruction affects any of the three arithmetic flags, its data write to this register does not reach any of the three. Flags whose enable is raised take the new result. The others keep their value. As a result, clearing the register through a clear-destination instruction leaves it as `000u u1uu`. Instructions that change no flags, such as bit set or clear, nibble swap and move from the working register, write the flags exactly as given. The carry and half-byte carry are stored as the ALU drives them. In subtraction they therefore hold an active-low borrow: they read 1 when no borrow occurred. The two reset-cause bits cannot be written by software. They are set only by power-on reset and are cleared by their events.

Top module: `status_flag_reg`

## Requirements
- R1: While and after `rstN` is low, `statusOut` reads 8'h18: bit 4 (watchdog-expiry flag, active low) = 1, bit 3 (sleep flag, active low) = 1, all other bits 0.
- R2: For each flag (bit 2 zero, bit 1 half-byte carry, bit 0 carry), a high `flagUpd` bit on a clock edge loads the matching `aluFlags` bit, whatever `wrEn` and `wrData` are. `flagUpd`/`aluFlags` index 2 maps to bit 2, index 1 to bit 1 and index 0 to bit 0.
- R3: When `flagUpd` is all zero and `wrEn` is high, bits 2:0 take `wrData[2:0]` on that edge.
- R4: When `flagUpd` is all zero and `wrEn` is low, bits 2:0 keep their value.
- R5: Bits 7:5 of `statusOut` always read 0, whatever is written.
- R6: Bits 4 and 3 are never changed by `wrEn`/`wrData`. In particular, neither rises except through reset.
- R7: A high `wdtTimeout` on a clock edge makes bit 4 read 0 after that edge.
- R8: A high `sleepEvt` on a clock edge makes bit 3 read 0 after that edge.
- R9: When any `flagUpd` bit is high, the data write reaches none of bits 2:0, and flags whose enable is low keep their value. Clearing the register with `flagUpd`=3'b100, `aluFlags[2]`=1 and `wrData`=0 gives `000u u1uu`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Power-on reset, active low, synchronous |
| aluFlags | input | 3 | Flag results {zero, half carry, carry} |
| flagUpd | input | 3 | Per-flag update enables, same order |
| wrEn | input | 1 | Data write to the status register |
| wrData | input | 8 | Data written |
| wdtTimeout | input | 1 | Watchdog expired event |
| sleepEvt | input | 1 | Sleep instruction executed event |
| statusOut | output | 8 | Current status byte |

## Verification
The assertions treat the enables, the write strobe and the events as clean single-cycle levels sampled at the edge. They assume that reset is asserted from time zero, so that nothing is checked before the register has a defined value. The stimulus changes inputs only just after a rising edge and holds `rstN` low across the first edges. The sweep crosses every enable pattern with every flag value, both write states and data bytes chosen to set and clear every bit, including the reserved and reset-cause bits. The events are applied only in a separate phase, so that their one-way effect does not hide the write checks.

// File: rtl/statreg_pkg.sv
package statreg_pkg;
  localparam int NUM_FLAGS = 3;
  localparam int REG_W     = 8;
  localparam int TO_BIT    = 4;
  localparam int PD_BIT    = 3;
  localparam int RSV_LO    = 5;

  typedef struct packed {
    logic [NUM_FLAGS-1:0] takeAlu;
    logic [NUM_FLAGS-1:0] takeWr;
    logic                 clrTo;
    logic                 clrPd;
  } strobes_t;
endpackage

// File: rtl/statreg_ctrl.sv
module statreg_ctrl
  import statreg_pkg::*;
(
  input  logic [NUM_FLAGS-1:0] flagUpd,
  input  logic                 wrEn,
  input  logic                 wdtTimeout,
  input  logic                 sleepEvt,
  output strobes_t             strb
);
  logic anyUpd;

  always_comb begin
    anyUpd       = |flagUpd;
    strb.takeAlu = flagUpd;
    strb.takeWr  = {NUM_FLAGS{wrEn & ~anyUpd}};
    strb.clrTo   = wdtTimeout;
    strb.clrPd   = sleepEvt;
  end
endmodule

// File: rtl/statreg_dp.sv
module statreg_dp
  import statreg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  strobes_t             strb,
  input  logic [NUM_FLAGS-1:0] aluFlags,
  input  logic [REG_W-1:0]     wrData,
  output logic [REG_W-1:0]     statusOut
);
  logic [NUM_FLAGS-1:0] flagQ;
  logic                 toQ;
  logic                 pdQ;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN)                flagQ[i] <= 1'b0;
      else if (strb.takeAlu[i]) flagQ[i] <= aluFlags[i];
      else if (strb.takeWr[i])  flagQ[i] <= wrData[i];
    end

    AST_ALU_WINS: assert property (@(posedge clk) disable iff (!rstN)
      strb.takeAlu[i] |=> flagQ[i] == $past(aluFlags[i])); // R2
    AST_WR_LANDS: assert property (@(posedge clk) disable iff (!rstN)
      (strb.takeWr[i] && !strb.takeAlu[i]) |=> flagQ[i] == $past(wrData[i])); // R3
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (!strb.takeWr[i] && !strb.takeAlu[i]) |=> $stable(flagQ[i])); // R4
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      toQ <= 1'b1;
      pdQ <= 1'b1;
    end else begin
      if (strb.clrTo) toQ <= 1'b0;
      if (strb.clrPd) pdQ <= 1'b0;
    end
  end

  always_comb begin
    statusOut                      = '0;
    statusOut[NUM_FLAGS-1:0]       = flagQ;
    statusOut[TO_BIT]              = toQ;
    statusOut[PD_BIT]              = pdQ;
  end

  AST_TO_NO_RISE: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(toQ)); // R6
  AST_PD_NO_RISE: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(pdQ)); // R6
  AST_TO_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrTo |=> !toQ); // R7
  AST_PD_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrPd |=> !pdQ); // R8
endmodule

// File: rtl/status_flag_reg.sv
module status_flag_reg
  import statreg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_FLAGS-1:0] aluFlags,
  input  logic [NUM_FLAGS-1:0] flagUpd,
  input  logic                 wrEn,
  input  logic [REG_W-1:0]     wrData,
  input  logic                 wdtTimeout,
  input  logic                 sleepEvt,
  output logic [REG_W-1:0]     statusOut
);
  strobes_t strb;

  statreg_ctrl ctrl_i (
    .flagUpd    (flagUpd),
    .wrEn       (wrEn),
    .wdtTimeout (wdtTimeout),
    .sleepEvt   (sleepEvt),
    .strb       (strb)
  );

  statreg_dp dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .aluFlags  (aluFlags),
    .wrData    (wrData),
    .statusOut (statusOut)
  );

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    statusOut[REG_W-1:RSV_LO] == '0); // R5
  AST_RESET_VAL: assert property (@(posedge clk)
    !rstN |=> statusOut == 8'h18); // R1
  AST_WR_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (|flagUpd && !flagUpd[0]) |=> statusOut[0] == $past(statusOut[0])); // R9
endmodule

// File: tb/status_flag_reg_tb.sv
module status_flag_reg_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] aluFlags = '0;
  logic [2:0] flagUpd = '0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       wdtTimeout = 1'b0;
  logic       sleepEvt = 1'b0;
  logic [7:0] statusOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [2:0] mFlags;
  logic mTo, mPd;

  always #2 clk = ~clk;

  status_flag_reg dut_i (
    .clk(clk), .rstN(rstN), .aluFlags(aluFlags), .flagUpd(flagUpd),
    .wrEn(wrEn), .wrData(wrData), .wdtTimeout(wdtTimeout),
    .sleepEvt(sleepEvt), .statusOut(statusOut)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model();
    return {3'b000, mTo, mPd, mFlags};
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic doReset();
    rstN = 1'b0; flagUpd = '0; wrEn = 1'b0; wdtTimeout = 1'b0; sleepEvt = 1'b0;
    step(); step();
    mFlags = '0; mTo = 1'b1; mPd = 1'b1;
    check("R1 reset value", statusOut, 8'h18);
    rstN = 1'b1;
  endtask

  initial begin
    logic [7:0] pats [8] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'hE7, 8'h18, 8'h07, 8'hE0};
    step();
    doReset();
    for (int u = 0; u < 8; u++) begin
      for (int a = 0; a < 8; a++) begin
        for (int w = 0; w < 2; w++) begin
          for (int p = 0; p < 8; p++) begin
            string tag;
            flagUpd = u[2:0]; aluFlags = a[2:0]; wrEn = w[0]; wrData = pats[p];
            for (int b = 0; b < 3; b++)
              if (u[b]) mFlags[b] = a[b];
              else if (u == 0 && w == 1) mFlags[b] = pats[p][b];
            if (u != 0) tag = (w == 1) ? "R9 write masked, R2 alu" : "R2 alu update";
            else tag = (w == 1) ? "R3 write lands" : "R4 hold";
            step();
            check(tag, {5'b0, statusOut[2:0]}, {5'b0, mFlags});
            check("R5 R6 upper bits", statusOut[7:3], model() >> 3);
          end
        end
      end
    end
    flagUpd = '0; wrEn = 1'b0;
    // R9 clear-register case: 000u u1uu
    wrEn = 1'b1; wrData = 8'h03; step(); mFlags = 3'b011;
    flagUpd = 3'b100; aluFlags = 3'b100; wrData = 8'h00; step(); mFlags[2] = 1'b1;
    check("R9 clear gives 000uu1uu", statusOut, 8'h1F);
    flagUpd = '0; wrEn = 1'b0;
    // R7 watchdog expiry
    wdtTimeout = 1'b1; step(); wdtTimeout = 1'b0; mTo = 1'b0;
    check("R7 watchdog clears bit4", statusOut, model());
    wrEn = 1'b1; wrData = 8'hFF; step(); mFlags = 3'b111;
    check("R6 write cannot set bit4", statusOut, model());
    // R8 sleep
    wrEn = 1'b0; sleepEvt = 1'b1; step(); sleepEvt = 1'b0; mPd = 1'b0;
    check("R8 sleep clears bit3", statusOut, model());
    wrEn = 1'b1; wrData = 8'hFF; step(); wrEn = 1'b0;
    check("R6 write cannot set bit3", statusOut, model());
    doReset();
    check("R1 reset restores after events", statusOut, 8'h18);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end
endmodule